// File: doc/BRIEF.md
# Wrapping Auto Channel Scan Sequencer

This block produces the 3-bit multiplexer address that selects one of eight analog inputs ahead of a converter. In fixed mode the address simply follows a channel number supplied by the host. In scan mode the block walks through a window of channels, from a start channel to an end channel. It moves one step each time the converter reports that a conversion has finished. The end channel may sit numerically below the start channel. The walk then runs up through channel 7, rolls over to channel 0 and continues to the end channel before it returns to the start.

Scanning runs only while both the scan enable and the master hardware enable are high. Software is expected to load the window limits first, then the scan enable, and to raise the master enable last. The address output is the current channel, so the same value can be shown in status readback. Conversion timing and data capture are handled elsewhere.

Top module: `chan_scan_seq`

## Requirements
- R1: While rst_n is low, the stored scan position is 0, so with both enables high the chan output reads 0.
- R2: When scan_en and hw_en are not both high, chan equals fixed_ch in the same cycle, with no clock edge in between.
- R3: With scan_en high and hw_en low, conv_done pulses have no effect and chan keeps following fixed_ch.
- R4: On the first clock edge at which scan_en and hw_en are both high, the position is loaded with first_ch.
- R5: While scanning, a clock edge with conv_done high moves chan from c to c+1 when c is not last_ch.
- R6: When last_ch is below first_ch, the step from channel 7 goes to channel 0, and the walk goes on up to last_ch.
- R7: While scanning, a clock edge with conv_done high at chan equal to last_ch sets chan back to first_ch.
- R8: When first_ch equals last_ch, chan stays on that channel across any number of conv_done pulses.
- R9: While scanning, a clock edge with conv_done low leaves chan unchanged.
- R10: While scanning, a change of first_ch or last_ch reloads the position with first_ch at the next edge. This reload takes precedence over a conv_done pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Selects automatic scan |
| hw_en | input | 1 | Master hardware enable, needed for scan |
| first_ch | input | 3 | Start channel of the scan window |
| last_ch | input | 3 | End channel of the scan window |
| fixed_ch | input | 3 | Channel used when not scanning |
| conv_done | input | 1 | One-cycle pulse when a conversion finishes |
| chan | output | 3 | Multiplexer channel address |

## Verification
In fixed mode the output is a combinational function of fixed_ch, so the bench checks it in the same cycle the input changes, before any clock edge. Every scan result comes from the single position register and is due one edge after its cause: the enable rising, a conv_done pulse or a limit change. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. The expected next channel comes from an independent model of the wrap rule.

// File: rtl/chan_scan_seq.sv
module chan_scan_seq #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            hw_en,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic [CH_W-1:0] fixed_ch,
  input  logic            conv_done,
  output logic [CH_W-1:0] chan
);

  logic            active;
  logic            active_q;
  logic [CH_W-1:0] pos;
  logic [CH_W-1:0] first_q;
  logic [CH_W-1:0] last_q;
  logic            reload;
  logic [CH_W-1:0] step;

  assign active = scan_en & hw_en;
  assign reload = active & (~active_q | (first_ch != first_q) | (last_ch != last_q));
  assign step   = (pos == last_ch) ? first_ch : pos + 1'b1;
  assign chan   = active ? pos : fixed_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
      pos      <= '0;
    end else begin
      active_q <= active;
      first_q  <= first_ch;
      last_q   <= last_ch;
      if (reload)
        pos <= first_ch;
      else if (active && conv_done)
        pos <= step;
    end
  end

endmodule

module chan_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_en,
  input logic            hw_en,
  input logic [CH_W-1:0] first_ch,
  input logic [CH_W-1:0] last_ch,
  input logic [CH_W-1:0] fixed_ch,
  input logic            conv_done,
  input logic [CH_W-1:0] chan
);

  logic on;
  logic up;
  assign on = scan_en & hw_en;

  always_ff @(posedge clk) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  // R2
  fixed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> chan == fixed_ch);

  // R4
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && on && !$past(on)) |=> (!on || chan == $past(first_ch)));

  // R5 R6 R7
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && on && $past(on) && conv_done && $stable(first_ch) && $stable(last_ch))
    |=> (!on || chan == (($past(chan) == $past(last_ch)) ? $past(first_ch) : $past(chan) + 1'b1)));

  // R9
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && on && $past(on) && !conv_done && $stable(first_ch) && $stable(last_ch))
    |=> (!on || chan == $past(chan)));

  // R10
  limit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && on && $past(on) && (!$stable(first_ch) || !$stable(last_ch)))
    |=> (!on || chan == $past(first_ch)));

endmodule

bind chan_scan_seq chan_scan_seq_chk #(.CH_W(CH_W)) i_chan_scan_seq_chk (.*);

// File: tb/test_chan_scan_seq.sv
module test_chan_scan_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0;
  logic       hw_en = 1'b0;
  logic [2:0] first_ch = '0;
  logic [2:0] last_ch = '0;
  logic [2:0] fixed_ch = '0;
  logic       conv_done = 1'b0;
  logic [2:0] chan;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_scan_seq i_chan_scan_seq (.*);

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (chan !== exp) begin
      errors++;
      $display("FAIL %s chan=%0d expected=%0d", req, chan, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] model_next(input logic [2:0] c, input logic [2:0] f, input logic [2:0] l);
    return (c == l) ? f : 3'((c + 1) % 8);
  endfunction

  task automatic stop_scan();
    scan_en = 1'b0; hw_en = 1'b0; conv_done = 1'b0;
    tick();
  endtask

  task automatic start_scan(input logic [2:0] f, input logic [2:0] l);
    first_ch = f; last_ch = l; scan_en = 1'b1;
    tick();
    hw_en = 1'b1;
    tick();
    check("R4", f);
  endtask

  task automatic pulse_steps(input string req, input int n, input logic [2:0] f, input logic [2:0] l);
    logic [2:0] exp = chan;
    for (int i = 0; i < n; i++) begin
      conv_done = 1'b1;
      tick();
      conv_done = 1'b0;
      exp = model_next(exp, f, l);
      check(req, exp);
    end
  endtask

  task automatic t_reset();
    scan_en = 1'b1; hw_en = 1'b1; fixed_ch = 3'd5;
    tick();
    check("R1", 3'd0);
    scan_en = 1'b0; hw_en = 1'b0;
    #1;
    check("R2", 3'd5);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_fixed();
    for (int v = 0; v < 8; v += 3) begin
      fixed_ch = 3'(v);
      #1;
      check("R2", 3'(v));
    end
    @(negedge clk);
  endtask

  task automatic t_gate();
    fixed_ch = 3'd6; first_ch = 3'd1; last_ch = 3'd3; scan_en = 1'b1; hw_en = 1'b0;
    tick();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    check("R3", 3'd6);
    fixed_ch = 3'd2;
    #1;
    check("R3", 3'd2);
    stop_scan();
  endtask

  task automatic t_plain();
    start_scan(3'd2, 3'd5);
    pulse_steps("R5", 3, 3'd2, 3'd5);
    pulse_steps("R7", 1, 3'd2, 3'd5);
    check("R7", 3'd2);
    stop_scan();
  endtask

  task automatic t_wrap();
    start_scan(3'd6, 3'd1);
    pulse_steps("R6", 1, 3'd6, 3'd1);
    check("R6", 3'd7);
    pulse_steps("R6", 1, 3'd6, 3'd1);
    check("R6", 3'd0);
    pulse_steps("R6", 2, 3'd6, 3'd1);
    check("R7", 3'd6);
    stop_scan();
  endtask

  task automatic t_single();
    start_scan(3'd4, 3'd4);
    pulse_steps("R8", 3, 3'd4, 3'd4);
    check("R8", 3'd4);
    stop_scan();
  endtask

  task automatic t_hold();
    start_scan(3'd0, 3'd7);
    pulse_steps("R5", 2, 3'd0, 3'd7);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R9", 3'd2);
    end
    stop_scan();
  endtask

  task automatic t_reload();
    start_scan(3'd1, 3'd6);
    pulse_steps("R5", 2, 3'd1, 3'd6);
    last_ch = 3'd7; conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    check("R10", 3'd1);
    first_ch = 3'd5;
    tick();
    check("R10", 3'd5);
    pulse_steps("R5", 1, 3'd5, 3'd7);
    stop_scan();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fixed();
    t_gate();
    t_plain();
    t_wrap();
    t_single();
    t_hold();
    t_reload();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule